// File: doc/BRIEF.md
# Dual-Channel DAC Serial Control Front End

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host sends it 16-bit words over an SPI-style link. The link has a serial clock, a data line and an active-low frame-select line. Each word carries a 4-bit command in its top bits and a 12-bit payload. The block decodes the command and acts on it. It can load a channel's staging register, move staged values into the output registers, clear the outputs, change its own serial settings, or arm a readback of an output register.

Each channel keeps a staging register and an output register, so the two outputs can change together. An active-low load pin copies both staging registers into the output registers while it is held low. An active-low clear pin forces both outputs to zero or to half scale. The serial output pin has two uses. It can pass the previously shifted word on to the next device in a chain, or it can return an output register to the host. Every external pin is oversampled by a fast system clock through two-flop synchronisers. The two 12-bit output codes feed the analog converter cores.

Top module: `dual_dac_spi_front`

## Requirements
- R1: A word is 16 bits, sent MSB first: bits [15:12] are the command and bits [11:0] the payload. It is acted on when frame-select rises, and only if exactly 16 sampling edges were seen while frame-select was low. A shorter or longer frame changes no register.
- R2: After reset both output codes and both staging registers are zero and the serial output is low. Data is sampled on the falling clock edge and chaining is enabled.
- R3: Command 0x1 writes the payload to the channel A staging and output registers, and 0x3 does the same for channel B. Command 0x5 writes the payload to both staging registers only. Command 0x6 copies both staging registers into the output registers. Command 0x7 writes the payload to all four registers.
- R4: An output register changes only on 0x1, 0x3, 0x6, 0x7, 0xA or 0xB, on the load pin or on the clear pin.
- R5: While the load pin is low, each output register takes its staging register's value on every clock.
- R6: While the clear pin is low, both outputs are forced to zero, or to 0x800 when the clear-to-half-scale control bit is set. This takes precedence over every other source.
- R7: Command 0xA sets both output registers to 0 and 0xB sets them to 0x800. The staging registers keep their values.
- R8: Command 0x9 switches sampling to the rising clock edge from the next frame on. The serial output then changes on falling edges.
- R9: With chaining on, during a frame the serial output presents the 16 bits held in the shift register before that frame, MSB first. The first bit appears before the first sampling edge, and each later bit appears after each launch edge. Command 0x8 turns chaining off, and the serial output then stays low.
- R10: Command 0x2 (channel A) or 0x4 (channel B) makes the next frame shift out {4'b0000, output register} MSB first on the serial output, in place of chain data, whatever the chaining setting.
- R11: Command 0xD loads the control settings from the payload: bits [11:10] are the output mode (2'b11 holds the serial output low), bit 9 enables chaining, bit 8 selects clear-to-half-scale, bit 7 selects rising-edge sampling. Bits [6:0] are ignored.
- R12: Clock pauses while frame-select stays low do not split a frame. Two 8-bit bytes sent under one low frame-select form one word.
- R13: Commands 0x0, 0xC, 0xE and 0xF change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Serial clock from the host |
| sync_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| ldac_n_i | input | 1 | Active-low level-sensitive load of the output registers |
| clr_n_i | input | 1 | Active-low clear of the output registers |
| sdo_o | output | 1 | Serial data out for chaining or readback |
| code_a_o | output | 12 | Channel A output code |
| code_b_o | output | 12 | Channel B output code |

## Verification
The assertions check several rules on every cycle. The output codes must hold steady when no frame, load or clear is active. The load pin must make the outputs track the staging registers. The clear pin must give zero or half scale according to the control bit. The serial output must stay quiet between frames. Only the bench scenarios show the rest: command decoding, the discarding of short and long frames, byte-split frames, the readback bit order, chain pass-through, and the switch between sampling edges.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP       = 4'h0,
    CMD_WRUP_A    = 4'h1,
    CMD_RDBK_A    = 4'h2,
    CMD_WRUP_B    = 4'h3,
    CMD_RDBK_B    = 4'h4,
    CMD_LD_BOTH   = 4'h5,
    CMD_UP_BOTH   = 4'h6,
    CMD_WRUP_BOTH = 4'h7,
    CMD_CHAIN_OFF = 4'h8,
    CMD_EDGE_RISE = 4'h9,
    CMD_CLR_ZERO  = 4'hA,
    CMD_CLR_MID   = 4'hB,
    CMD_RSV_C     = 4'hC,
    CMD_CTRL      = 4'hD,
    CMD_RSV_E     = 4'hE,
    CMD_RSV_F     = 4'hF
  } cmd_e;

  // Field order matches payload bits [11:7]
  typedef struct packed {
    logic [1:0] sdo_mode;
    logic       chain_en;
    logic       clr_mid;
    logic       rise_edge;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{sdo_mode: 2'b00, chain_en: 1'b1,
                                 clr_mid: 1'b0, rise_edge: 1'b0};
  localparam logic [1:0] SDO_MODE_OFF = 2'b11;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sync_n_s,
  input  logic               sdi_s,
  input  logic               rise_edge,
  input  logic               chain_en,
  input  logic               rb_req,
  input  logic [FRAME_W-1:0] rb_word,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word,
  output logic               sync_fall,
  output logic               sdo_q
);

  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int MSB     = FRAME_W - 1;

  logic               sclk_d, sync_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [FRAME_W-1:0] rb_sr_q, rb_sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               rb_on_q, rb_on_d;
  logic               sdo_d;
  logic               sclk_rise, sclk_fall, smp_edge, lch_edge, in_frame, sync_rise;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_d;
    sclk_fall = ~sclk_s & sclk_d;
    smp_edge  = rise_edge ? sclk_rise : sclk_fall;
    lch_edge  = rise_edge ? sclk_fall : sclk_rise;
    in_frame  = ~sync_n_s;
    sync_fall = sync_d & ~sync_n_s;
    sync_rise = ~sync_d & sync_n_s;
    frame_vld = sync_rise && (cnt_q == CNT_W'(FRAME_W));
  end

  always_comb begin
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    rb_sr_d = rb_sr_q;
    rb_on_d = rb_on_q;
    sdo_d   = sdo_q;
    if (!in_frame) begin
      cnt_d   = '0;
      rb_on_d = 1'b0;
    end else if (smp_edge) begin
      sr_d = {sr_q[MSB-1:0], sdi_s};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end
    if (sync_fall) begin
      rb_on_d = rb_req;
      rb_sr_d = rb_word;
      sdo_d   = rb_req ? rb_word[MSB] : (chain_en & sr_q[MSB]);
    end else if (in_frame && lch_edge) begin
      if (rb_on_q) begin
        sdo_d   = rb_sr_q[MSB-1];
        rb_sr_d = rb_sr_q << 1;
      end else begin
        sdo_d = chain_en & sr_q[MSB];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b1;
      sync_d  <= 1'b1;
      sr_q    <= '0;
      cnt_q   <= '0;
      rb_sr_q <= '0;
      rb_on_q <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      sync_d  <= sync_n_s;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      rb_sr_q <= rb_sr_d;
      rb_on_q <= rb_on_d;
      sdo_q   <= sdo_d;
    end
  end

  assign frame_word = sr_q;

endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
  import dacif_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_vld,
  input  logic [CMD_W+DATA_W-1:0]   frame_word,
  input  logic                      sync_fall,
  input  logic                      ldac_n_s,
  input  logic                      clr_n_s,
  output ctrl_t                     ctrl,
  output logic                      rb_pend,
  output logic [CMD_W+DATA_W-1:0]   rb_word,
  output logic [DATA_W-1:0]         inp_a,
  output logic [DATA_W-1:0]         inp_b,
  output logic [DATA_W-1:0]         code_a,
  output logic [DATA_W-1:0]         code_b
);

  localparam int FRAME_W            = CMD_W + DATA_W;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);
  localparam int CTRL_BITS          = $bits(ctrl_t);

  logic [DATA_W-1:0] inp_a_d, inp_b_d, dac_a_q, dac_a_d, dac_b_q, dac_b_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              rb_pend_q, rb_pend_d, rb_sel_q, rb_sel_d;
  logic [DATA_W-1:0] inp_a_q, inp_b_q;
  cmd_e              cmd;
  logic [DATA_W-1:0] dat;

  always_comb begin
    cmd       = cmd_e'(frame_word[FRAME_W-1 -: CMD_W]);
    dat       = frame_word[DATA_W-1:0];
    inp_a_d   = inp_a_q;
    inp_b_d   = inp_b_q;
    dac_a_d   = dac_a_q;
    dac_b_d   = dac_b_q;
    ctrl_d    = ctrl_q;
    rb_pend_d = rb_pend_q;
    rb_sel_d  = rb_sel_q;
    if (sync_fall) rb_pend_d = 1'b0;
    if (frame_vld) begin
      case (cmd)
        CMD_WRUP_A:    begin inp_a_d = dat; dac_a_d = dat; end
        CMD_WRUP_B:    begin inp_b_d = dat; dac_b_d = dat; end
        CMD_RDBK_A:    begin rb_pend_d = 1'b1; rb_sel_d = 1'b0; end
        CMD_RDBK_B:    begin rb_pend_d = 1'b1; rb_sel_d = 1'b1; end
        CMD_LD_BOTH:   begin inp_a_d = dat; inp_b_d = dat; end
        CMD_UP_BOTH:   begin dac_a_d = inp_a_q; dac_b_d = inp_b_q; end
        CMD_WRUP_BOTH: begin
          inp_a_d = dat; inp_b_d = dat; dac_a_d = dat; dac_b_d = dat;
        end
        CMD_CHAIN_OFF: ctrl_d.chain_en = 1'b0;
        CMD_EDGE_RISE: ctrl_d.rise_edge = 1'b1;
        CMD_CLR_ZERO:  begin dac_a_d = '0; dac_b_d = '0; end
        CMD_CLR_MID:   begin dac_a_d = MID; dac_b_d = MID; end
        CMD_CTRL:      ctrl_d = ctrl_t'(dat[DATA_W-1 -: CTRL_BITS]);
        default:       ;
      endcase
    end
    if (!ldac_n_s) begin
      dac_a_d = inp_a_d;
      dac_b_d = inp_b_d;
    end
    if (!clr_n_s) begin
      dac_a_d = ctrl_q.clr_mid ? MID : '0;
      dac_b_d = ctrl_q.clr_mid ? MID : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inp_a_q   <= '0;
      inp_b_q   <= '0;
      dac_a_q   <= '0;
      dac_b_q   <= '0;
      ctrl_q    <= CTRL_RST;
      rb_pend_q <= 1'b0;
      rb_sel_q  <= 1'b0;
    end else begin
      inp_a_q   <= inp_a_d;
      inp_b_q   <= inp_b_d;
      dac_a_q   <= dac_a_d;
      dac_b_q   <= dac_b_d;
      ctrl_q    <= ctrl_d;
      rb_pend_q <= rb_pend_d;
      rb_sel_q  <= rb_sel_d;
    end
  end

  assign ctrl    = ctrl_q;
  assign rb_pend = rb_pend_q;
  assign rb_word = {{CMD_W{1'b0}}, (rb_sel_q ? dac_b_q : dac_a_q)};
  assign inp_a   = inp_a_q;
  assign inp_b   = inp_b_q;
  assign code_a  = dac_a_q;
  assign code_b  = dac_b_q;

endmodule

// File: rtl/dual_dac_spi_front.sv
module dual_dac_spi_front
  import dacif_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sync_n_i,
  input  logic              sdi_i,
  input  logic              ldac_n_i,
  input  logic              clr_n_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o
);

  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int PIN_N   = 5;
  // order {sdi, clr_n, ldac_n, sync_n, sclk}
  localparam logic [PIN_N-1:0] PIN_RST = 5'b01111;

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [PIN_N-1:0]   pins_s;
  logic               sclk_s, sync_n_s, ldac_s, clr_s, sdi_s;
  logic               frame_vld, sync_fall, sdo_q, rb_pend;
  logic [FRAME_W-1:0] frame_word, rb_word;
  logic [DATA_W-1:0]  inp_a, inp_b;
  ctrl_t              ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  dacif_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({sdi_i, clr_n_i, ldac_n_i, sync_n_i, sclk_i}),
    .q     (pins_s)
  );
  assign {sdi_s, clr_s, ldac_s, sync_n_s, sclk_s} = pins_s;

  dacif_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sclk_s     (sclk_s),
    .sync_n_s   (sync_n_s),
    .sdi_s      (sdi_s),
    .rise_edge  (ctrl.rise_edge),
    .chain_en   (ctrl.chain_en),
    .rb_req     (rb_pend),
    .rb_word    (rb_word),
    .frame_vld  (frame_vld),
    .frame_word (frame_word),
    .sync_fall  (sync_fall),
    .sdo_q      (sdo_q)
  );

  dacif_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .frame_vld  (frame_vld),
    .frame_word (frame_word),
    .sync_fall  (sync_fall),
    .ldac_n_s   (ldac_s),
    .clr_n_s    (clr_s),
    .ctrl       (ctrl),
    .rb_pend    (rb_pend),
    .rb_word    (rb_word),
    .inp_a      (inp_a),
    .inp_b      (inp_b),
    .code_a     (code_a_o),
    .code_b     (code_b_o)
  );

  assign sdo_o = sdo_q & (ctrl.sdo_mode != SDO_MODE_OFF);

endmodule

// File: rtl/dacif_chk.sv
module dacif_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_vld,
  input logic              sync_s,
  input logic              ldac_s,
  input logic              clr_s,
  input logic              clr_mid,
  input logic [DATA_W-1:0] inp_a,
  input logic [DATA_W-1:0] inp_b,
  input logic [DATA_W-1:0] code_a,
  input logic [DATA_W-1:0] code_b,
  input logic              sdo
);

  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_vld && clr_s && ldac_s) |=> ($stable(code_a) && $stable(code_b))); // R4

  AST_LDAC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldac_s && clr_s) |=> (code_a == inp_a && code_b == inp_b)); // R5

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !clr_mid) |=> (code_a == '0 && code_b == '0)); // R6

  AST_CLR_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && clr_mid) |=> (code_a == MID && code_b == MID)); // R6

  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_s && !frame_vld) |=> $stable(sdo)); // R9

endmodule

bind dual_dac_spi_front dacif_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .frame_vld (frame_vld),
  .sync_s    (sync_n_s),
  .ldac_s    (ldac_s),
  .clr_s     (clr_s),
  .clr_mid   (ctrl.clr_mid),
  .inp_a     (inp_a),
  .inp_b     (inp_b),
  .code_a    (code_a_o),
  .code_b    (code_b_o),
  .sdo       (sdo_o)
);

// File: tb/dual_dac_spi_front_tb.sv
module dual_dac_spi_front_tb;

  logic clk = 1'b0;
  logic rst_n, sclk, sync_n, sdi, ldac_n, clr_n;
  logic sdo;
  logic [11:0] code_a, code_b;

  always #4 clk = ~clk;

  dual_dac_spi_front u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdi_i(sdi),
    .ldac_n_i(ldac_n), .clr_n_i(clr_n), .sdo_o(sdo),
    .code_a_o(code_a), .code_b_o(code_b)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit chk_en = 0;
  string cur_tag = "R2";

  // behavioural reference state
  logic [11:0] e_a = 0, e_b = 0, m_ia = 0, m_ib = 0;
  logic [15:0] m_sr = 0;
  logic [1:0]  m_mode = 0;
  bit m_chain = 1, m_mid = 0, m_rise = 0, m_rb_pend = 0, m_rb_sel = 0;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      check({cur_tag, " codes"}, {8'h0, code_a, code_b}, {8'h0, e_a, e_b});
    end
  end

  task automatic model_apply(input logic [15:0] w);
    logic [11:0] d;
    d = w[11:0];
    case (w[15:12])
      4'h1: begin m_ia = d; e_a = d; end
      4'h3: begin m_ib = d; e_b = d; end
      4'h2: begin m_rb_pend = 1; m_rb_sel = 0; end
      4'h4: begin m_rb_pend = 1; m_rb_sel = 1; end
      4'h5: begin m_ia = d; m_ib = d; end
      4'h6: begin e_a = m_ia; e_b = m_ib; end
      4'h7: begin m_ia = d; m_ib = d; e_a = d; e_b = d; end
      4'h8: m_chain = 0;
      4'h9: m_rise = 1;
      4'hA: begin e_a = 0; e_b = 0; end
      4'hB: begin e_a = 12'h800; e_b = 12'h800; end
      4'hD: begin m_mode = d[11:10]; m_chain = d[9]; m_mid = d[8]; m_rise = d[7]; end
      default: ;
    endcase
  endtask

  // sends n bits of w MSB first; bits past 16 are zero; gap pauses after byte one
  task automatic frame(input logic [15:0] w, input int n, input bit gap, input string tag);
    logic [15:0] rbw;
    bit rbon;
    logic eb, b;
    string stag;
    chk_en = 0;
    sclk = m_rise ? 1'b0 : 1'b1;
    wait_clk(6);
    rbon = m_rb_pend;
    rbw = {4'h0, (m_rb_sel ? e_b : e_a)};
    m_rb_pend = 0;
    stag = rbon ? "R10 sdo" : "R9 sdo";
    if (m_mode == 2'b11) stag = "R11 sdo";
    sync_n = 1'b0;
    wait_clk(6);
    for (int i = 0; i < n; i++) begin
      if (gap && i == 8) wait_clk(24);
      b = (i < 16) ? w[15-i] : 1'b0;
      sdi = b;
      if (m_mode == 2'b11) eb = 1'b0;
      else if (rbon) eb = (i < 16) ? rbw[15-i] : 1'b0;
      else eb = m_chain ? m_sr[15] : 1'b0;
      wait_clk(5);
      check(m_rise ? {stag, " R8"} : stag, {31'h0, sdo}, {31'h0, eb});
      sclk = ~sclk;
      m_sr = {m_sr[14:0], b};
      wait_clk(5);
      sclk = ~sclk;
      wait_clk(5);
    end
    wait_clk(5);
    sync_n = 1'b1;
    wait_clk(10);
    if (n == 16) model_apply(w);
    cur_tag = tag;
    chk_en = 1;
    wait_clk(4);
  endtask

  initial begin
    rst_n = 0; sclk = 1; sync_n = 1; sdi = 0; ldac_n = 1; clr_n = 1;
    wait_clk(5);
    rst_n = 1;
    wait_clk(8);
    check("R2 code_a", {20'h0, code_a}, 32'h0);
    check("R2 code_b", {20'h0, code_b}, 32'h0);
    check("R2 sdo", {31'h0, sdo}, 32'h0);
    chk_en = 1;
    wait_clk(4);

    frame(16'h1ABC, 16, 0, "R3 R1 load-update A");
    frame(16'h3123, 16, 0, "R3 load-update B");
    frame(16'h5555, 16, 0, "R4 load both no output change");
    frame(16'h6000, 16, 0, "R3 update both");
    frame(16'h77E1, 16, 0, "R3 write all");
    frame(16'h1FFF, 12, 0, "R1 short frame ignored");
    frame(16'h3AAA, 16, 0, "R1 resync after short");
    frame(16'h1F0F, 16, 0, "R1 prime");
    frame(16'h1333, 17, 0, "R1 long frame ignored");
    frame(16'h12A5, 16, 1, "R12 split bytes");
    frame(16'h0FFF, 16, 0, "R13 nop");
    frame(16'hCFFF, 16, 0, "R13 reserved C");
    frame(16'hEFFF, 16, 0, "R13 reserved E");
    frame(16'hFFFF, 16, 0, "R13 reserved F");
    frame(16'h2000, 16, 0, "R10 arm readback A");
    frame(16'h4000, 16, 0, "R10 readback A shifted, arm B");
    frame(16'h0000, 16, 0, "R10 readback B shifted");

    frame(16'h53C3, 16, 0, "R4 stage 3C3");
    chk_en = 0;
    ldac_n = 0; wait_clk(8); ldac_n = 1;
    e_a = m_ia; e_b = m_ib;
    wait_clk(6); cur_tag = "R5 load pin"; chk_en = 1; wait_clk(4);

    frame(16'hB000, 16, 0, "R7 clear mid");
    frame(16'h6000, 16, 0, "R7 inputs kept");
    frame(16'hA000, 16, 0, "R7 clear zero");
    frame(16'h7456, 16, 0, "R3 restore");

    chk_en = 0;
    clr_n = 0; wait_clk(8);
    e_a = 0; e_b = 0; cur_tag = "R6 clear pin zero"; chk_en = 1; wait_clk(4);
    chk_en = 0; clr_n = 1; wait_clk(6); chk_en = 1; wait_clk(4);

    frame(16'hD300, 16, 0, "R11 ctrl half-scale clear");
    chk_en = 0;
    clr_n = 0; wait_clk(8);
    e_a = 12'h800; e_b = 12'h800; cur_tag = "R6 clear pin mid"; chk_en = 1; wait_clk(4);
    chk_en = 0; clr_n = 1; wait_clk(6); chk_en = 1; wait_clk(4);

    frame(16'h8000, 16, 0, "R9 chain off");
    frame(16'h1111, 16, 0, "R9 sdo low");
    frame(16'h2000, 16, 0, "R10 arm with chain off");
    frame(16'h0000, 16, 0, "R10 readback chain off");

    frame(16'h9000, 16, 0, "R8 rising edge");
    frame(16'h3BCD, 16, 0, "R8 load B on rising");
    frame(16'hD280, 16, 0, "R11 chain on rising");
    frame(16'h1777, 16, 0, "R8 R9 chain rising");
    frame(16'hDE80, 16, 0, "R11 sdo off");
    frame(16'h4000, 16, 0, "R11 arm readback B");
    frame(16'h0000, 16, 0, "R11 readback suppressed");
    frame(16'hD27F, 16, 0, "R11 back to falling, low bits ignored");
    frame(16'h3654, 16, 0, "R8 falling again");

    chk_en = 0;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule